// File: doc/BRIEF.md
# Banked SPI Configuration Register File

This block is the configuration store behind a serial control port. It keeps 16-bit registers in three banks and presents every stored value on wide parallel outputs, where the rest of the chip reads its settings. A host reaches the registers with 24-bit frames on a four-wire SPI link (mode 0). Each frame carries an 8-bit register address and then 16 data bits, both MSB first. The serial pins are oversampled by the system clock through two-flop synchronizers, so the serial clock must stay at each level for at least four system clock cycles.

The address space is split. A small global bank (bank 0) sits at addresses 0x00 to B0_N-1 and is reached whatever the bank setting. A window of BK_N addresses starting at BK_BASE is shared by bank 1 and bank 2. Bit 0 of the bank 0 register at 0x03 chooses which of the two banks answers in that window. That choice stays in force until 0x03 is written again, so a host selects a bank once and then writes any number of its registers. Bit 0 of the bank 0 register at 0x00 switches the port into read mode. In read mode a frame returns the addressed register on the data-out line and changes nothing, except for a frame to 0x00 itself, which still writes. That write is how the host leaves read mode.

Top module: `spi_cfg_regfile`

## Requirements
- R1: After reset every register in all three banks is zero, miso_o is 0, and the window addresses BK_BASE..BK_BASE+BK_N-1 write into bank 1.
- R2: A frame sends 8 address bits and then 16 data bits, MSB first, and each bit is sampled on a rising serial clock edge. The write takes effect after chip select rises, provided exactly 24 rising edges occurred while it was low.
- R3: A frame with any number of rising edges other than 24 (0 through 23, or 25 and more) changes no register.
- R4: Addresses 0x00..B0_N-1 always write bank 0 register (address), whichever bank bit 0 of register 0x03 selects, and such a write leaves banks 1 and 2 unchanged.
- R5: With bit 0 of register 0x03 at 0, window address BK_BASE+i writes bank 1 register i. With that bit at 1, it writes bank 2 register i. The bank that is not selected is left unchanged.
- R6: After a single bank-select write, any number of window writes go to the selected bank without selecting it again.
- R7: A 24-bit frame to an address outside bank 0 and outside the window changes no register.
- R8: While bit 0 of register 0x00 is 1, a 24-bit frame to any address other than 0x00 writes nothing. miso_o then carries the addressed register MSB first: bit 15 is valid before rising edge 9 and bit 0 before rising edge 24.
- R9: Reads in read mode use the same decoding as writes. Window addresses return the bank chosen by register 0x03, and unmapped addresses return 0.
- R10: A 24-bit frame to 0x00 is written even in read mode, after returning the old value. miso_o is 0 while chip select is high, during the address phase, and throughout frames that are not reads.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock; idles low; data sampled on its rising edge |
| cs_n_i | input | 1 | Active-low chip select; frames one access |
| mosi_i | input | 1 | Serial data from the host |
| miso_o | output | 1 | Serial read data to the host |
| bank0_o | output | B0_N*DATA_W | Bank 0 registers; register i at bits i*DATA_W +: DATA_W |
| bank1_o | output | BK_N*DATA_W | Bank 1 registers, same packing |
| bank2_o | output | BK_N*DATA_W | Bank 2 registers, same packing |

## Verification
The hardest state to reach is a read-mode frame that returns a window register from the bank that is not currently visible. Reaching it takes a full exit and re-entry sequence: a write to 0x00 that is accepted while read mode is on, then a bank-select write, then read mode switched on again. The bench runs this sequence and reads the whole window in both bank settings. It also sweeps every frame length from 0 to 32 edges around the one valid length, and it sweeps the unmapped addresses, so that rejected frames are shown to leave all three banks unchanged.

// File: rtl/spi_cfg_pkg.sv
package spi_cfg_pkg;

    // Result of decoding a register address against the current bank setting.
    typedef enum logic [1:0] {
        BANK_NONE = 2'd0,
        BANK_0    = 2'd1,
        BANK_1    = 2'd2,
        BANK_2    = 2'd3
    } bank_e;

endpackage

// File: rtl/cfg_addr_decode.sv
module cfg_addr_decode
    import spi_cfg_pkg::*;
#(
    parameter int unsigned ADDR_W  = 8,
    parameter int unsigned B0_N    = 8,
    parameter int unsigned BK_N    = 8,
    parameter int unsigned BK_BASE = 64,
    parameter int unsigned IDX_W   = 3
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              bank2_sel_i,
    output bank_e             bank_o,
    output logic [IDX_W-1:0]  idx_o
);

    localparam int unsigned BK_END = BK_BASE + BK_N;

    logic [ADDR_W-1:0] win_off;

    always_comb begin
        win_off = addr_i - ADDR_W'(BK_BASE);
        bank_o  = BANK_NONE;
        idx_o   = '0;
        // Global bank wins first: its addresses never overlap the window.
        if (32'(addr_i) < B0_N) begin
            bank_o = BANK_0;
            idx_o  = IDX_W'(addr_i);
        end else if ((32'(addr_i) >= BK_BASE) && (32'(addr_i) < BK_END)) begin
            bank_o = bank2_sel_i ? BANK_2 : BANK_1;
            idx_o  = IDX_W'(win_off);
        end
    end

endmodule

// File: rtl/spi_frame_rx.sv
module spi_frame_rx #(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_i,
    input  logic              cs_n_i,
    input  logic              mosi_i,
    input  logic              rd_en_i,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic [ADDR_W-1:0] hdr_addr_o,
    output logic              hdr_stb_o,
    output logic              done_o,
    output logic [ADDR_W-1:0] frame_addr_o,
    output logic [DATA_W-1:0] frame_data_o,
    output logic              miso_o
);

    localparam int unsigned FRAME_W = ADDR_W + DATA_W;
    localparam int unsigned CNT_MAX = FRAME_W + 1;
    localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);

    typedef struct packed {
        logic [1:0]         cs_s;
        logic [1:0]         ck_s;
        logic [1:0]         mo_s;
        logic               ck_l;
        logic               cs_l;
        logic [CNT_W-1:0]   cnt;
        logic [FRAME_W-1:0] sr;
        logic [DATA_W-1:0]  tx;
        logic               stb;
        logic               done;
    } rx_t;

    rx_t q, d;

    logic cs_n_s, ck_rise, cs_fall, cs_rise;

    always_comb begin
        cs_n_s  = q.cs_s[1];
        ck_rise = q.ck_s[1] & ~q.ck_l;
        cs_fall = ~q.cs_s[1] & q.cs_l;
        cs_rise = q.cs_s[1] & ~q.cs_l;

        d      = q;
        d.cs_s = {q.cs_s[0], cs_n_i};
        d.ck_s = {q.ck_s[0], sclk_i};
        d.mo_s = {q.mo_s[0], mosi_i};
        d.ck_l = q.ck_s[1];
        d.cs_l = q.cs_s[1];
        d.stb  = 1'b0;
        d.done = 1'b0;

        // Address complete one cycle ago: load the read word for the data phase.
        if (q.stb && rd_en_i) begin
            d.tx = rd_data_i;
        end

        if (cs_fall) begin
            d.cnt = '0;
            d.sr  = '0;
            d.tx  = '0;
        end else if (!cs_n_s && ck_rise) begin
            d.sr = {q.sr[FRAME_W-2:0], q.mo_s[1]};
            if (q.cnt != CNT_W'(CNT_MAX)) begin
                d.cnt = q.cnt + 1'b1;
            end
            if (q.cnt == CNT_W'(ADDR_W - 1)) begin
                d.stb = 1'b1;
            end
            if (q.cnt >= CNT_W'(ADDR_W)) begin
                d.tx = {q.tx[DATA_W-2:0], 1'b0};
            end
        end

        if (cs_rise) begin
            d.done = (q.cnt == CNT_W'(FRAME_W));
            d.tx   = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.cs_s <= 2'b11;
            q.cs_l <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign hdr_addr_o   = q.sr[ADDR_W-1:0];
    assign hdr_stb_o    = q.stb;
    assign done_o       = q.done;
    assign frame_addr_o = q.sr[FRAME_W-1:DATA_W];
    assign frame_data_o = q.sr[DATA_W-1:0];
    assign miso_o       = q.tx[DATA_W-1];

    // R3: the edge counter saturates and never runs past its ceiling.
    assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= CNT_W'(CNT_MAX));

    // R2: a commit is a single-cycle event.
    assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |=> !q.done);

    // R10: once chip select has been high for a cycle, the output line is quiet.
    assert_miso_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (q.cs_s[1] && q.cs_l) |-> !miso_o);

endmodule

// File: rtl/cfg_reg_banks.sv
module cfg_reg_banks
    import spi_cfg_pkg::*;
#(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned B0_N   = 8,
    parameter int unsigned BK_N   = 8,
    parameter int unsigned IDX_W  = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en_i,
    input  bank_e                  wr_bank_i,
    input  logic [IDX_W-1:0]       wr_idx_i,
    input  logic [DATA_W-1:0]      wr_data_i,
    input  bank_e                  rd_bank_i,
    input  logic [IDX_W-1:0]       rd_idx_i,
    output logic [DATA_W-1:0]      rd_data_o,
    output logic [B0_N*DATA_W-1:0] bank0_o,
    output logic [BK_N*DATA_W-1:0] bank1_o,
    output logic [BK_N*DATA_W-1:0] bank2_o
);

    typedef struct packed {
        logic [B0_N-1:0][DATA_W-1:0] b0;
        logic [BK_N-1:0][DATA_W-1:0] b1;
        logic [BK_N-1:0][DATA_W-1:0] b2;
    } regs_t;

    regs_t q, d;

    // Per-register write strobes, one set per bank.
    logic [B0_N-1:0] hit0;
    logic [BK_N-1:0] hit1, hit2;

    for (genvar g = 0; g < B0_N; g++) begin : g_hit0
        assign hit0[g] = wr_en_i && (wr_bank_i == BANK_0) && (wr_idx_i == IDX_W'(g));
    end
    for (genvar g = 0; g < BK_N; g++) begin : g_hitk
        assign hit1[g] = wr_en_i && (wr_bank_i == BANK_1) && (wr_idx_i == IDX_W'(g));
        assign hit2[g] = wr_en_i && (wr_bank_i == BANK_2) && (wr_idx_i == IDX_W'(g));
    end

    always_comb begin
        d = q;
        for (int i = 0; i < B0_N; i++) begin
            if (hit0[i]) d.b0[i] = wr_data_i;
        end
        for (int i = 0; i < BK_N; i++) begin
            if (hit1[i]) d.b1[i] = wr_data_i;
            if (hit2[i]) d.b2[i] = wr_data_i;
        end
    end

    always_comb begin
        rd_data_o = '0;
        for (int i = 0; i < B0_N; i++) begin
            if ((rd_bank_i == BANK_0) && (rd_idx_i == IDX_W'(i))) rd_data_o = q.b0[i];
        end
        for (int i = 0; i < BK_N; i++) begin
            if ((rd_bank_i == BANK_1) && (rd_idx_i == IDX_W'(i))) rd_data_o = q.b1[i];
            if ((rd_bank_i == BANK_2) && (rd_idx_i == IDX_W'(i))) rd_data_o = q.b2[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign bank0_o = q.b0;
    assign bank1_o = q.b1;
    assign bank2_o = q.b2;

    // R5: a write into one shared bank leaves the other one untouched.
    assert_b2_hold_on_b1_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && (wr_bank_i == BANK_1)) |=> $stable(q.b2));
    assert_b1_hold_on_b2_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && (wr_bank_i == BANK_2)) |=> $stable(q.b1));

    // R4: global-bank writes never reach the shared window.
    assert_b0_isolated_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && (wr_bank_i == BANK_0)) |=> ($stable(q.b1) && $stable(q.b2)));

    // R7: nothing moves without an accepted write to a mapped bank.
    assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en_i || (wr_bank_i == BANK_NONE)) |=> $stable(q));

    // R5: at most one register is strobed per cycle.
    assert_one_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({hit0, hit1, hit2}));

endmodule

// File: rtl/spi_cfg_regfile.sv
module spi_cfg_regfile
    import spi_cfg_pkg::*;
#(
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned DATA_W    = 16,
    parameter int unsigned B0_N      = 8,
    parameter int unsigned BK_N      = 8,
    parameter int unsigned BK_BASE   = 64,
    parameter int unsigned CTRL_ADDR = 0,
    parameter int unsigned RDEN_BIT  = 0,
    parameter int unsigned BSEL_ADDR = 3,
    parameter int unsigned BSEL_BIT  = 0
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   sclk_i,
    input  logic                   cs_n_i,
    input  logic                   mosi_i,
    output logic                   miso_o,
    output logic [B0_N*DATA_W-1:0] bank0_o,
    output logic [BK_N*DATA_W-1:0] bank1_o,
    output logic [BK_N*DATA_W-1:0] bank2_o
);

    localparam int unsigned MAX_N = (B0_N > BK_N) ? B0_N : BK_N;
    localparam int unsigned IDX_W = (MAX_N > 1) ? $clog2(MAX_N) : 1;

    logic              rd_mode, bank2_sel;
    logic [ADDR_W-1:0] hdr_addr, frm_addr;
    logic [DATA_W-1:0] frm_data, rd_data;
    logic              hdr_stb, frm_done, wr_en;
    bank_e             wr_bank, rd_bank;
    logic [IDX_W-1:0]  wr_idx, rd_idx;

    assign rd_mode   = bank0_o[CTRL_ADDR*DATA_W + RDEN_BIT];
    assign bank2_sel = bank0_o[BSEL_ADDR*DATA_W + BSEL_BIT];

    spi_frame_rx #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) rx_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .sclk_i       (sclk_i),
        .cs_n_i       (cs_n_i),
        .mosi_i       (mosi_i),
        .rd_en_i      (rd_mode),
        .rd_data_i    (rd_data),
        .hdr_addr_o   (hdr_addr),
        .hdr_stb_o    (hdr_stb),
        .done_o       (frm_done),
        .frame_addr_o (frm_addr),
        .frame_data_o (frm_data),
        .miso_o       (miso_o)
    );

    cfg_addr_decode #(
        .ADDR_W (ADDR_W), .B0_N (B0_N), .BK_N (BK_N),
        .BK_BASE(BK_BASE), .IDX_W (IDX_W)
    ) wr_dec_i (
        .addr_i      (frm_addr),
        .bank2_sel_i (bank2_sel),
        .bank_o      (wr_bank),
        .idx_o       (wr_idx)
    );

    cfg_addr_decode #(
        .ADDR_W (ADDR_W), .B0_N (B0_N), .BK_N (BK_N),
        .BK_BASE(BK_BASE), .IDX_W (IDX_W)
    ) rd_dec_i (
        .addr_i      (hdr_addr),
        .bank2_sel_i (bank2_sel),
        .bank_o      (rd_bank),
        .idx_o       (rd_idx)
    );

    // Read mode blocks every write except the one that can switch it off.
    assign wr_en = frm_done && (wr_bank != BANK_NONE)
                && (!rd_mode || (frm_addr == ADDR_W'(CTRL_ADDR)));

    cfg_reg_banks #(
        .DATA_W (DATA_W), .B0_N (B0_N), .BK_N (BK_N), .IDX_W (IDX_W)
    ) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en),
        .wr_bank_i (wr_bank),
        .wr_idx_i  (wr_idx),
        .wr_data_i (frm_data),
        .rd_bank_i (rd_bank),
        .rd_idx_i  (rd_idx),
        .rd_data_o (rd_data),
        .bank0_o   (bank0_o),
        .bank1_o   (bank1_o),
        .bank2_o   (bank2_o)
    );

    // R8: a completed frame in read mode to any other address changes no register.
    assert_read_no_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_done && rd_mode && (frm_addr != ADDR_W'(CTRL_ADDR)))
        |=> ($stable(bank0_o) && $stable(bank1_o) && $stable(bank2_o)));

    // R9: the header strobe arrives with chip select still framing the access.
    assert_hdr_in_frame_R9: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_stb |-> !frm_done);

endmodule

// File: tb/spi_cfg_regfile_tb.sv
module spi_cfg_regfile_tb_top;

    localparam int N  = 8;
    localparam int HP = 6;
    localparam int WD = 190000;

    logic clk = 1'b0;
    logic rst_n, sclk, cs_n, mosi;
    logic miso;
    logic [N*16-1:0] b0, b1, b2;

    always #2.5 clk = ~clk;

    spi_cfg_regfile dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .sclk_i  (sclk),
        .cs_n_i  (cs_n),
        .mosi_i  (mosi),
        .miso_o  (miso),
        .bank0_o (b0),
        .bank1_o (b1),
        .bank2_o (b2)
    );

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    logic [15:0] m0 [N];
    logic [15:0] m1 [N];
    logic [15:0] m2 [N];

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    function automatic bit in_window(input logic [7:0] a);
        return (a >= 8'h40) && (a < 8'h48);
    endfunction

    function automatic logic [15:0] model_read(input logic [7:0] a);
        if (a < 8'(N)) return m0[a[2:0]];
        if (in_window(a)) return m0[3][0] ? m2[a[2:0]] : m1[a[2:0]];
        return 16'h0000;
    endfunction

    task automatic model_write(input logic [7:0] a, input logic [15:0] v);
        if (a < 8'(N)) m0[a[2:0]] = v;
        else if (in_window(a)) begin
            if (m0[3][0]) m2[a[2:0]] = v;
            else          m1[a[2:0]] = v;
        end
    endtask

    task automatic wait_hp();
        repeat (HP) @(negedge clk);
    endtask

    task automatic compare_regs(input string tag);
        logic [N*16-1:0] e0, e1, e2;
        for (int i = 0; i < N; i++) begin
            e0[i*16 +: 16] = m0[i];
            e1[i*16 +: 16] = m1[i];
            e2[i*16 +: 16] = m2[i];
        end
        check(b0 == e0, tag, "bank0", b0, e0);
        check(b1 == e1, tag, "bank1", b1, e1);
        check(b2 == e2, tag, "bank2", b2, e2);
    endtask

    task automatic send_frame(input logic [7:0] a, input logic [15:0] v,
                              input int nbits, input string tag);
        logic [23:0] word;
        logic        rdm;
        logic [15:0] expv, got;
        logic        stray;
        word  = {a, v};
        rdm   = m0[0][0];
        expv  = rdm ? model_read(a) : 16'h0000;
        got   = 16'h0000;
        stray = 1'b0;
        cs_n = 1'b0;
        wait_hp();
        for (int k = 1; k <= nbits; k++) begin
            mosi = (k <= 24) ? word[24-k] : 1'b0;
            wait_hp();
            if (k >= 9 && k <= 24) got[24-k] = miso;
            else if (miso !== 1'b0) stray = 1'b1;
            sclk = 1'b1;
            wait_hp();
            sclk = 1'b0;
        end
        wait_hp();
        cs_n = 1'b1;
        repeat (4) wait_hp();
        if (miso !== 1'b0) stray = 1'b1;
        if (nbits == 24 && (!rdm || a == 8'h00)) model_write(a, v);
        if (nbits == 24) begin
            if (rdm) check(got == expv && !stray, "R8", "read word", {stray, got}, {1'b0, expv});
            else     check(got == 16'h0 && !stray, "R10", "idle miso", {stray, got}, 17'h0);
        end else begin
            check(!stray, "R10", "miso outside data", stray, 1'b0);
        end
        compare_regs(tag);
    endtask

    initial begin
        repeat (WD) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog all-requirements: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < N; i++) begin
            m0[i] = '0; m1[i] = '0; m2[i] = '0;
        end
        rst_n = 1'b0; sclk = 1'b0; cs_n = 1'b1; mosi = 1'b0;
        repeat (10) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R1: reset state, then a window write must land in bank 1.
        compare_regs("R1");
        check(miso == 1'b0, "R1", "miso after reset", miso, 1'b0);
        send_frame(8'h42, 16'hBEEF, 24, "R1");
        check(b1[2*16 +: 16] == 16'hBEEF, "R1", "default bank1", b1[2*16 +: 16], 16'hBEEF);

        // R2 / R4: global bank sweep (control register left alone).
        for (int a = 1; a < N; a++)
            send_frame(8'(a), (16'h1357 * 16'(a + 1)) ^ 16'h0F00, 24, "R2");

        // R5: select bank 1 and fill the window, then bank 2.
        send_frame(8'h03, 16'h7A10, 24, "R5");
        for (int i = 0; i < N; i++)
            send_frame(8'h40 + 8'(i), 16'hA000 + 16'(i) * 16'h0111, 24, "R5");
        send_frame(8'h03, 16'h7A11, 24, "R5");
        // R6: many writes after one selection.
        for (int i = 0; i < N; i++)
            send_frame(8'h40 + 8'(i), 16'h5000 ^ (16'(i) * 16'h0303), 24, "R6");
        // R4: global write while bank 2 is selected, then R6 again.
        send_frame(8'h05, 16'hC0DE, 24, "R4");
        send_frame(8'h44, 16'hF00D, 24, "R6");

        // R7: unmapped addresses.
        for (int a = 8; a < 256; a += 5)
            if (!in_window(8'(a)))
                send_frame(8'(a), (16'(a) * 16'h0101) ^ 16'hFFFF, 24, "R7");

        // R3: every wrong frame length around 24.
        for (int n = 0; n <= 32; n++)
            if (n != 24) send_frame(8'h01, 16'hC3C3 ^ 16'(n), n, "R3");

        // R8: enter read mode, read the global bank and try writes.
        send_frame(8'h00, 16'h0001, 24, "R8");
        for (int a = 1; a < N; a++) send_frame(8'(a), 16'hFFFF, 24, "R8");
        send_frame(8'h00, 16'h00F1, 24, "R10");
        // R9: window reads with bank 2 selected, unmapped reads.
        for (int i = 0; i < N; i++) send_frame(8'h40 + 8'(i), 16'h1111, 24, "R9");
        send_frame(8'h20, 16'h2222, 24, "R9");
        send_frame(8'h80, 16'h3333, 24, "R9");
        send_frame(8'hFF, 16'h4444, 24, "R9");

        // R10: leave read mode, switch to bank 1, re-enter, read window.
        send_frame(8'h00, 16'h0000, 24, "R10");
        send_frame(8'h03, 16'h0000, 24, "R9");
        send_frame(8'h00, 16'h0001, 24, "R9");
        for (int i = 0; i < N; i++) send_frame(8'h40 + 8'(i), 16'h9999, 24, "R9");
        send_frame(8'h00, 16'h0000, 24, "R10");
        send_frame(8'h01, 16'h600D, 24, "R10");

        finished = 1'b1;
        summary();
        $finish;
    end

endmodule